// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block sits on the external side of a bus controller. It compares each transfer address against a set of address windows and drives the chip select of the matching window together with that window's read strobe, write strobe and an address-valid pulse. It then counts wait states and returns a transfer acknowledge for every beat.

Each window has these settings, supplied as static configuration inputs:
- an enable,
- a base address,
- a block size given as a power of two,
- a port-width code,
- a read-only flag,
- a wait count for the first beat and a second wait count for every later beat.

A window is aligned to its own size: the base bits below the block size take no part in the compare. When several windows overlap, the lowest-numbered one is used. A write that lands in a read-only window drives no strobe and ends with a one-cycle bus error instead of acknowledges.

A transfer starts with a one-cycle `bus_start` pulse that carries the address, the direction and the beat count minus one. The block then reports `busy` until the last acknowledge has been given. It accepts no new start while busy. Memory devices, splitting a transfer by port width and the bus master are outside this block.

Top module: `chip_sel_decoder`

## Requirements
- R1: Window i matches when it is enabled and bus_addr equals cfg_base in every bit at or above position cfg_size (block size 2^cfg_size). Base bits below that position are ignored. A size of at least the address width matches every address.
- R2: When several windows match, the one with the lowest index is used. When none matches, a start drives no chip select, no strobe, no ack and no bus error, and busy stays low.
- R3: During a transfer exactly one cs_n bit is low, for the selected window. Its oe_n bit is low for a read, or its we_n bit is low for a write. All other strobe bits stay high.
- R4: adv_n is low in the first cycle of a transfer only (the cycle after the start is sampled), and high otherwise.
- R5: When a start is sampled at clock edge E, the strobes go active in the cycle after E. The first ack is high in active cycle pwait+1, where pwait is the window's first-beat wait count.
- R6: Each later ack is high exactly swait+1 cycles after the previous one, where swait is the window's later-beat wait count.
- R7: A transfer gives exactly bus_nbeats_m1+1 ack pulses. In the cycle after the last ack, all strobes are high and busy is low.
- R8: A write to a window whose cfg_ro bit is 1 drives no strobe and no ack. berr is high for exactly the one cycle after the start. A read of such a window runs normally.
- R9: While busy, port_width carries the 2-bit width code of the selected window (0 = 8-bit, 1 = 16-bit, 2 = 32-bit). It is 0 when idle.
- R10: A bus_start that arrives while busy is ignored. The current transfer keeps its chip select and ack count.
- R11: While rst is high and after its release, every cs_n, oe_n and we_n bit and adv_n are high, and ack, berr and busy are low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | NUM_CS | Window enable per chip select |
| cfg_base | input | NUM_CS*ADDR_W | Base address per window, packed from index 0 upward |
| cfg_size | input | NUM_CS*SZ_W | Block size exponent per window |
| cfg_width | input | NUM_CS*2 | Port width code per window |
| cfg_ro | input | NUM_CS | Read-only flag per window |
| cfg_pwait | input | NUM_CS*WAIT_W | First-beat wait count per window |
| cfg_swait | input | NUM_CS*WAIT_W | Later-beat wait count per window |
| bus_start | input | 1 | One-cycle transfer request |
| bus_addr | input | ADDR_W | Transfer address, sampled with bus_start |
| bus_write | input | 1 | 1 = write, 0 = read, sampled with bus_start |
| bus_nbeats_m1 | input | BEAT_W | Beat count minus one, sampled with bus_start |
| cs_n | output | NUM_CS | Chip selects, active low |
| oe_n | output | NUM_CS | Read enables, active low |
| we_n | output | NUM_CS | Write enables, active low |
| adv_n | output | 1 | Address-valid strobe, active low |
| ack | output | 1 | Transfer acknowledge, one pulse per beat |
| berr | output | 1 | Bus error for a blocked write |
| busy | output | 1 | Transfer in progress |
| port_width | output | 2 | Width code of the selected window |

## Verification
The assertions assume the following about the inputs:
- bus_start is a single-cycle pulse.
- The configuration does not change while a transfer is busy. The block latches only the wait count for later beats and the width code, and reads every other setting at the start.

The bench changes window settings only between transfers, once busy is low again. It drives bus_start high for one cycle per request. The bench breaks the single-pulse rule on purpose only once, for R10, and then only while busy is high; the block must ignore that pulse.

// File: rtl/csd_pkg.sv
package csd_pkg;

   // Port-width codes carried per window and presented on port_width.
   typedef enum logic [1:0] {
      PW_8    = 2'd0,
      PW_16   = 2'd1,
      PW_32   = 2'd2,
      PW_RSVD = 2'd3
   } pw_e;

   localparam int PW_BITS = 2;

endpackage

// File: rtl/csd_match.sv
// Aligned window compare for one chip select.
module csd_match #(
   parameter int ADDR_W = 24,
   parameter int SZ_W   = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SZ_W-1:0]   size_log2,
   input  logic              en,
   output logic              hit
);

   logic [ADDR_W-1:0] keep;

   always_comb begin
      if (32'(size_log2) >= ADDR_W) begin
         keep = '0;
      end else begin
         keep = ~((ADDR_W'(1) << size_log2) - ADDR_W'(1));
      end
      hit = en && (((addr ^ base) & keep) == '0);
   end

endmodule

// File: rtl/csd_prio.sv
// Fixed priority select: the lowest set request index wins.
module csd_prio #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/csd_seq.sv
// Transfer sequencer: accepts a start, counts wait states, acks beats.
module csd_seq #(
   parameter int WAIT_W = 4,
   parameter int BEAT_W = 2,
   parameter int IW     = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              write,
   input  logic [BEAT_W-1:0] nbeats_m1,
   input  logic              hit,
   input  logic [IW-1:0]     hit_idx,
   input  logic              hit_ro,
   input  logic [WAIT_W-1:0] hit_pwait,
   input  logic [WAIT_W-1:0] hit_swait,
   input  logic [1:0]        hit_width,
   output logic              active,
   output logic              first,
   output logic              ack,
   output logic              berr,
   output logic [IW-1:0]     cur_idx,
   output logic              cur_wr,
   output logic [1:0]        cur_width
);

   logic [WAIT_W-1:0] cnt;
   logic [WAIT_W-1:0] swait_q;
   logic [BEAT_W-1:0] beats_left;
   logic              accept;
   logic              blocked;

   assign blocked = hit && write && hit_ro;
   assign accept  = !active && start && hit && !blocked;
   assign ack     = active && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         active     <= 1'b0;
         first      <= 1'b0;
         berr       <= 1'b0;
         cnt        <= '0;
         swait_q    <= '0;
         beats_left <= '0;
         cur_idx    <= '0;
         cur_wr     <= 1'b0;
         cur_width  <= '0;
      end else begin
         berr <= !active && start && blocked;
         if (accept) begin
            active     <= 1'b1;
            first      <= 1'b1;
            cnt        <= hit_pwait;
            swait_q    <= hit_swait;
            beats_left <= nbeats_m1;
            cur_idx    <= hit_idx;
            cur_wr     <= write;
            cur_width  <= hit_width;
         end else if (active) begin
            first <= 1'b0;
            if (cnt == '0) begin
               if (beats_left == '0) begin
                  active    <= 1'b0;
                  cur_width <= '0;
               end else begin
                  beats_left <= beats_left - BEAT_W'(1);
                  cnt        <= swait_q;
               end
            end else begin
               cnt <= cnt - WAIT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/csd_strobe.sv
// Per-window strobe generation from the sequencer state.
module csd_strobe #(
   parameter int NUM_CS = 4,
   parameter int IW     = 2
) (
   input  logic              active,
   input  logic              first,
   input  logic [IW-1:0]     idx,
   input  logic              wr,
   output logic [NUM_CS-1:0] cs_n,
   output logic [NUM_CS-1:0] oe_n,
   output logic [NUM_CS-1:0] we_n,
   output logic              adv_n
);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      logic sel;
      assign sel     = active && (idx == IW'(i));
      assign cs_n[i] = !sel;
      assign oe_n[i] = !(sel && !wr);
      assign we_n[i] = !(sel && wr);
   end

   assign adv_n = !(active && first);

endmodule

// File: rtl/chip_sel_decoder.sv
module chip_sel_decoder
   import csd_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int ADDR_W = 24,
   parameter int WAIT_W = 4,
   parameter int BEAT_W = 2,
   parameter int SZ_W   = $clog2(ADDR_W + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_CS-1:0]        cfg_en,
   input  logic [NUM_CS*ADDR_W-1:0] cfg_base,
   input  logic [NUM_CS*SZ_W-1:0]   cfg_size,
   input  logic [NUM_CS*2-1:0]      cfg_width,
   input  logic [NUM_CS-1:0]        cfg_ro,
   input  logic [NUM_CS*WAIT_W-1:0] cfg_pwait,
   input  logic [NUM_CS*WAIT_W-1:0] cfg_swait,
   input  logic                     bus_start,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_write,
   input  logic [BEAT_W-1:0]        bus_nbeats_m1,
   output logic [NUM_CS-1:0]        cs_n,
   output logic [NUM_CS-1:0]        oe_n,
   output logic [NUM_CS-1:0]        we_n,
   output logic                     adv_n,
   output logic                     ack,
   output logic                     berr,
   output logic                     busy,
   output logic [1:0]               port_width
);

   localparam int IW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   initial begin
      assert (NUM_CS >= 1 && NUM_CS <= 32) else $error("NUM_CS out of range");
      assert (ADDR_W >= 8 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (WAIT_W >= 1 && WAIT_W <= 8)  else $error("WAIT_W out of range");
      assert (BEAT_W >= 1 && BEAT_W <= 4)  else $error("BEAT_W out of range");
      assert ((1 << SZ_W) > ADDR_W)        else $error("SZ_W too narrow");
      assert (PW_BITS == 2)                else $error("width code must be 2 bits");
   end

   logic [NUM_CS-1:0] hit_vec;
   logic [WAIT_W-1:0] pw_arr [NUM_CS];
   logic [WAIT_W-1:0] sw_arr [NUM_CS];
   logic [1:0]        wd_arr [NUM_CS];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_win
      csd_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
         .addr      (bus_addr),
         .base      (cfg_base[i*ADDR_W +: ADDR_W]),
         .size_log2 (cfg_size[i*SZ_W +: SZ_W]),
         .en        (cfg_en[i]),
         .hit       (hit_vec[i])
      );
      assign pw_arr[i] = cfg_pwait[i*WAIT_W +: WAIT_W];
      assign sw_arr[i] = cfg_swait[i*WAIT_W +: WAIT_W];
      assign wd_arr[i] = cfg_width[i*2 +: 2];
   end

   logic          any_hit;
   logic [IW-1:0] hit_idx;

   csd_prio #(.N(NUM_CS), .IW(IW)) u_prio (
      .req (hit_vec),
      .any (any_hit),
      .idx (hit_idx)
   );

   logic [IW-1:0] cur_idx;
   logic          cur_wr;
   logic          first;

   csd_seq #(.WAIT_W(WAIT_W), .BEAT_W(BEAT_W), .IW(IW)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (bus_start),
      .write     (bus_write),
      .nbeats_m1 (bus_nbeats_m1),
      .hit       (any_hit),
      .hit_idx   (hit_idx),
      .hit_ro    (cfg_ro[hit_idx]),
      .hit_pwait (pw_arr[hit_idx]),
      .hit_swait (sw_arr[hit_idx]),
      .hit_width (wd_arr[hit_idx]),
      .active    (busy),
      .first     (first),
      .ack       (ack),
      .berr      (berr),
      .cur_idx   (cur_idx),
      .cur_wr    (cur_wr),
      .cur_width (port_width)
   );

   csd_strobe #(.NUM_CS(NUM_CS), .IW(IW)) u_strobe (
      .active (busy),
      .first  (first),
      .idx    (cur_idx),
      .wr     (cur_wr),
      .cs_n   (cs_n),
      .oe_n   (oe_n),
      .we_n   (we_n),
      .adv_n  (adv_n)
   );

endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [NUM_CS-1:0] cs_n,
   input logic [NUM_CS-1:0] oe_n,
   input logic [NUM_CS-1:0] we_n,
   input logic              adv_n,
   input logic              ack,
   input logic              berr,
   input logic              busy
);

   AST_CS_ONEHOT:     assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));                     // R3
   AST_CS_WHEN_BUSY:  assert property (@(posedge clk) disable iff (rst) busy |-> $countones(~cs_n) == 1);    // R3
   AST_RW_EXCL:       assert property (@(posedge clk) disable iff (rst) ((~oe_n) & (~we_n)) == '0);          // R3
   AST_STROBE_IN_CS:  assert property (@(posedge clk) disable iff (rst) (((~oe_n) | (~we_n)) & cs_n) == '0); // R3
   AST_ADV_SINGLE:    assert property (@(posedge clk) disable iff (rst) !adv_n |=> adv_n);                   // R4
   AST_ADV_IN_XFER:   assert property (@(posedge clk) disable iff (rst) !adv_n |-> busy);                    // R4
   AST_ACK_IN_XFER:   assert property (@(posedge clk) disable iff (rst) ack |-> busy);                       // R7
   AST_ACK_BERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(ack && berr));                     // R8
   AST_BERR_NO_CS:    assert property (@(posedge clk) disable iff (rst) berr |-> (&cs_n && !busy));          // R8
   AST_BERR_PULSE:    assert property (@(posedge clk) disable iff (rst) berr |=> !berr);                     // R8
   AST_CS_HELD:       assert property (@(posedge clk) disable iff (rst) (busy && !ack) |=> $stable(cs_n));   // R10

endmodule

bind chip_sel_decoder csd_chk #(.NUM_CS(NUM_CS)) u_csd_chk (
   .clk   (clk),
   .rst   (rst),
   .cs_n  (cs_n),
   .oe_n  (oe_n),
   .we_n  (we_n),
   .adv_n (adv_n),
   .ack   (ack),
   .berr  (berr),
   .busy  (busy)
);

// File: tb/tb_chip_sel_decoder.sv
`timescale 1ns/1ps
module tb_chip_sel_decoder;

   localparam int NCS = 4;
   localparam int AW  = 24;
   localparam int WW  = 4;
   localparam int BW  = 2;
   localparam int SW  = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [NCS-1:0]    cfg_en;
   logic [NCS*AW-1:0] cfg_base;
   logic [NCS*SW-1:0] cfg_size;
   logic [NCS*2-1:0]  cfg_width;
   logic [NCS-1:0]    cfg_ro;
   logic [NCS*WW-1:0] cfg_pwait, cfg_swait;
   logic              bus_start = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic              bus_write = 1'b0;
   logic [BW-1:0]     bus_nbeats_m1 = '0;
   logic [NCS-1:0]    cs_n, oe_n, we_n;
   logic              adv_n, ack, berr, busy;
   logic [1:0]        port_width;

   chip_sel_decoder #(.NUM_CS(NCS), .ADDR_W(AW), .WAIT_W(WW), .BEAT_W(BW)) dut (.*);

   // Bench-side copy of the window settings, used by the model.
   int m_base [NCS], m_size [NCS], m_wd [NCS], m_pw [NCS], m_sw [NCS];
   bit m_en [NCS], m_ro [NCS];

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, fails = 0;

   typedef struct { int at; int cs; bit err; string req; } exp_t;
   exp_t sb [$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic apply_cfg();
      for (int i = 0; i < NCS; i++) begin
         cfg_en[i]              = m_en[i];
         cfg_ro[i]              = m_ro[i];
         cfg_base[i*AW +: AW]   = AW'(m_base[i]);
         cfg_size[i*SW +: SW]   = SW'(m_size[i]);
         cfg_width[i*2 +: 2]    = 2'(m_wd[i]);
         cfg_pwait[i*WW +: WW]  = WW'(m_pw[i]);
         cfg_swait[i*WW +: WW]  = WW'(m_sw[i]);
      end
   endtask

   function automatic int model_hit(input int a);
      for (int i = 0; i < NCS; i++) begin
         if (m_en[i]) begin
            if (m_size[i] >= AW) return i;
            if ((a >> m_size[i]) == (m_base[i] >> m_size[i])) return i;
         end
      end
      return -1;
   endfunction

   // Driver: issues one transfer and pushes the expected ack/berr events.
   task automatic run_xfer(input int a, input bit w, input int nb,
                           input int exp_cs, input bit poke = 1'b0);
      int h, n, t, total;
      bit blk;
      h = model_hit(a);
      chk(h == exp_cs, "R1 R2", "model window", h, exp_cs);
      blk = (h >= 0) && w && m_ro[h];
      @(negedge clk);
      n = cyc;
      bus_addr = AW'(a); bus_write = w; bus_nbeats_m1 = BW'(nb - 1); bus_start = 1'b1;
      if (h >= 0 && !blk) begin
         t = n + 1 + m_pw[h];
         for (int b = 0; b < nb; b++) begin
            sb.push_back('{at: t, cs: h, err: 1'b0, req: (b == 0) ? "R5" : "R6"});
            t += 1 + m_sw[h];
         end
      end else if (blk) begin
         sb.push_back('{at: n + 1, cs: -1, err: 1'b1, req: "R8"});
      end
      @(negedge clk);
      bus_start = 1'b0;
      if (h >= 0 && !blk) begin
         chk(cs_n == ~(NCS'(1) << h), "R3", "cs_n first cycle", cs_n, ~(NCS'(1) << h));
         chk(oe_n == (w ? '1 : ~(NCS'(1) << h)), "R3", "oe_n", oe_n, w ? '1 : ~(NCS'(1) << h));
         chk(we_n == (w ? ~(NCS'(1) << h) : '1), "R3", "we_n", we_n, w ? ~(NCS'(1) << h) : '1);
         chk(adv_n == 1'b0, "R4", "adv_n first cycle", adv_n, 0);
         chk(port_width == 2'(m_wd[h]), "R9", "port_width", port_width, m_wd[h]);
         total = m_pw[h] + nb + (nb - 1) * m_sw[h];
         for (int k = 0; k < total; k++) begin
            if (poke && k == 0) begin
               bus_addr = '0; bus_write = 1'b0; bus_start = 1'b1;
            end
            @(negedge clk);
            bus_start = 1'b0;
            if (k == 0 && total > 1) chk(adv_n == 1'b1, "R4", "adv_n second cycle", adv_n, 1);
            if (poke && k == 0) chk(cs_n == ~(NCS'(1) << h), "R10", "cs_n after busy start", cs_n, ~(NCS'(1) << h));
         end
         chk(cs_n == '1 && oe_n == '1 && we_n == '1 && !busy, "R7", "release after last ack",
             {busy, cs_n}, {1'b0, {NCS{1'b1}}});
         chk(port_width == 2'd0, "R9", "port_width idle", port_width, 0);
      end else begin
         chk(cs_n == '1 && oe_n == '1 && we_n == '1, blk ? "R8" : "R2", "no strobes", {cs_n, oe_n, we_n}, '1);
         chk(busy == 1'b0 && ack == 1'b0, blk ? "R8" : "R2", "no transfer", {busy, ack}, 0);
         chk(berr == blk, blk ? "R8" : "R2", "berr", berr, blk);
         @(negedge clk);
         chk(berr == 1'b0 && cs_n == '1, blk ? "R8" : "R2", "quiet after", {berr, cs_n}, {1'b0, {NCS{1'b1}}});
      end
      chk(sb.size() == 0, "R7", "pending events", sb.size(), 0);
   endtask

   // Monitor: pops an expected event for every ack or berr seen.
   always @(negedge clk) begin
      if (!rst && (ack || berr)) begin
         if (sb.size() == 0) begin
            chk(1'b0, ack ? "R7" : "R8", "unexpected event", {ack, berr}, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(cyc == e.at, e.req, "event cycle", cyc, e.at);
            chk(berr == e.err && ack == !e.err, e.req, "event kind", {ack, berr}, {!e.err, e.err});
            if (!e.err) chk(cs_n == ~(NCS'(1) << e.cs), "R3", "cs_n at ack", cs_n, ~(NCS'(1) << e.cs));
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // window 0: 1 MiB at 0x100000, 32-bit, waits 2/1
      m_en[0]=1; m_base[0]=32'h100000; m_size[0]=20; m_wd[0]=2; m_ro[0]=0; m_pw[0]=2; m_sw[0]=1;
      // window 1: 64 KiB at 0, 16-bit, read-only, waits 0/0
      m_en[1]=1; m_base[1]=32'h000000; m_size[1]=16; m_wd[1]=1; m_ro[1]=1; m_pw[1]=0; m_sw[1]=0;
      // window 2: 32 KiB at 0x108000 (inside window 0), 8-bit, waits 3/2
      m_en[2]=1; m_base[2]=32'h108000; m_size[2]=15; m_wd[2]=0; m_ro[2]=0; m_pw[2]=3; m_sw[2]=2;
      // window 3: 8 MiB, base with low bits set, disabled at first, waits 1/3
      m_en[3]=0; m_base[3]=32'h801234; m_size[3]=23; m_wd[3]=2; m_ro[3]=0; m_pw[3]=1; m_sw[3]=3;
      apply_cfg();
      repeat (3) @(negedge clk);
      chk(cs_n == '1 && oe_n == '1 && we_n == '1 && adv_n, "R11", "strobes in reset", {cs_n, adv_n}, '1);
      chk(!ack && !berr && !busy && port_width == 0, "R11", "flags in reset", {ack, berr, busy}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(cs_n == '1 && !busy && !ack, "R11", "idle after reset", {busy, cs_n}, {1'b0, {NCS{1'b1}}});

      run_xfer(32'h100010, 1'b0, 1, 0);          // R5 single read
      run_xfer(32'h1FFFFC, 1'b1, 4, 0);          // R6 R7 top of window, 4 beats
      run_xfer(32'h200000, 1'b0, 1, -1);         // R1 just past window 0
      run_xfer(32'h0FFFFF, 1'b0, 1, -1);         // R1 outside window 1
      run_xfer(32'h00FFFF, 1'b0, 2, 1);          // R8 read of read-only ok, R6 swait 0
      run_xfer(32'h000004, 1'b1, 3, 1);          // R8 blocked write
      run_xfer(32'h108010, 1'b1, 2, 0);          // R2 overlap, lowest wins
      m_en[0] = 0; apply_cfg();
      run_xfer(32'h108010, 1'b0, 3, 2);          // R2 next window, R9 8-bit
      run_xfer(32'h900000, 1'b1, 1, -1);         // R2 disabled window
      m_en[3] = 1; apply_cfg();
      run_xfer(32'h800000, 1'b1, 2, 3);          // R1 low base bits ignored
      run_xfer(32'hFFFFFF, 1'b0, 4, 3);          // R1 top address
      m_en[0] = 1; apply_cfg();
      run_xfer(32'h100100, 1'b0, 2, 0, 1'b1);    // R10 start while busy
      repeat (4) @(negedge clk);
      chk(sb.size() == 0 && !busy, "R10", "no extra transfer", {busy, 8'(sb.size())}, 0);
      finish_run();
   end

endmodule